// File: doc/BRIEF.md
# I2C Channel-Select Target

This block is an I2C target that owns a single 8-bit channel mask. Each mask bit drives one enable output, and each enable output opens the path to one downstream bus segment. The block runs on a fast system clock. It first passes SCL and SDA through a two-flop synchronizer and a short majority-free glitch filter. It then detects START, repeated START and STOP, and shifts bytes in MSB first. It acknowledges its own address and answers reads with the mask. It drives SDA only through an open-drain pull-low output.

The 7-bit address is 1110 followed by three strap inputs, which gives a range of 0x70 to 0x77. The straps are captured when a START is seen.

A written mask is only staged at first. The enable outputs change after the next STOP, so every segment joins the bus while the bus is idle. When a write carries several data bytes, the last one is the one that counts.

Top module: `i2c_chan_sel`

## Requirements
- R1: While rst_n is low, and after it is released, chan_en_o is 0x00 and sda_pull_o is 0. A reset in the middle of a transaction also clears the staged mask, so a following read returns 0x00.
- R2: The address byte is received MSB first; bit 0 is R/W, with 0 meaning write and 1 meaning read. When bits 7..1 equal {1110, strap}, the block pulls SDA low during the ninth clock high period.
- R3: An address that does not match gets no acknowledge. The block then ignores the bus until the next START or STOP: the data bytes that follow get no acknowledge and leave the mask unchanged.
- R4: A data byte written after a matching write address is acknowledged and staged. chan_en_o keeps its previous value until a STOP, then takes the staged byte, with bit n enabling channel n.
- R5: When a write carries several data bytes, each byte is acknowledged and the STOP applies the last one.
- R6: A read returns the staged mask MSB first, with SDA pulled low for a 0 bit. After the controller sends a NACK, SDA is released.
- R7: When the controller acknowledges a read byte, the block sends the mask again as the next byte.
- R8: A repeated START drops any partly received byte and restarts address matching. A byte staged before the repeated START is still applied at the final STOP.
- R9: The straps are sampled at START. A change to the straps during a transaction has no effect until the next START.
- R10: A pulse on SCL or SDA that lasts fewer than FILT system clocks is rejected. It neither clocks a bit nor forms a START or STOP.
- R11: sda_pull_o changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Sensed SCL line level |
| sda_i | input | 1 | Sensed SDA line level |
| strap_i | input | 3 | Low three address bits |
| sda_pull_o | output | 1 | 1 = pull SDA low (open drain) |
| chan_en_o | output | 8 | Per-segment enable, bit n = channel n |

## Verification
The bench drives the block with single-byte writes, burst writes, single reads and reads with an acknowledge, addresses that do not match, and straps that change in the middle of a transaction. Together these patterns separate the staged mask from the applied mask, show that the last byte wins, and show that the straps are latched at START. Repeated STARTs are sent both after a complete data byte and after a partial one, to show that an aborted byte is dropped while the earlier staged byte survives. Two-clock pulses on SCL and on SDA, placed in the middle of a byte, show that the filter rejects them. A reset in the middle of a transaction shows that both the applied and the staged mask are cleared.

// File: rtl/i2c_chan_sel.sv
module i2c_chan_sel #(
  parameter int         FILT    = 3,
  parameter logic [3:0] ADDR_HI = 4'b1110
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] strap_i,
  output logic       sda_pull_o,
  output logic [7:0] chan_en_o
);
  localparam int CW = $clog2(FILT + 1);
  localparam logic [CW-1:0] CLIM = CW'(FILT - 1);

  typedef enum logic [2:0] {IDLE, ADDR, AACK, WDATA, WACK, RDATA, RACK} st_t;

  logic [1:0]    raw, s1, s2, f, q;
  logic [CW-1:0] fc [2];
  st_t           st;
  logic [3:0]    bcnt;
  logic [7:0]    sh, pend;
  logic [2:0]    strap_q;
  logic          rw, ph;

  assign raw = {sda_i, scl_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '1; s2 <= '1; f <= '1; q <= '1;
      fc[0] <= '0; fc[1] <= '0;
    end else begin
      s1 <= raw;
      s2 <= s1;
      q  <= f;
      for (int i = 0; i < 2; i++) begin
        if (s2[i] == f[i])       fc[i] <= '0;
        else if (fc[i] == CLIM) begin f[i] <= s2[i]; fc[i] <= '0; end
        else                     fc[i] <= fc[i] + 1'b1;
      end
    end
  end

  wire scl_f = f[0];
  wire sda_f = f[1];
  wire rise  = scl_f & ~q[0];
  wire fall  = ~scl_f & q[0];
  wire start = scl_f & q[0] & q[1] & ~sda_f;
  wire stop  = scl_f & q[0] & ~q[1] & sda_f;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE; bcnt <= '0; sh <= '0; pend <= '0; strap_q <= '0;
      rw <= 1'b0; ph <= 1'b0; sda_pull_o <= 1'b0; chan_en_o <= '0;
    end else if (start) begin
      st <= ADDR; bcnt <= '0; ph <= 1'b0; strap_q <= strap_i; sda_pull_o <= 1'b0;
    end else if (stop) begin
      st <= IDLE; sda_pull_o <= 1'b0; chan_en_o <= pend;
    end else begin
      case (st)
        ADDR: if (rise) begin
          sh   <= {sh[6:0], sda_f};
          bcnt <= bcnt + 1'b1;
          if (bcnt == 4'd7) begin
            rw <= sda_f;
            ph <= 1'b0;
            st <= (sh[6:0] == {ADDR_HI, strap_q}) ? AACK : IDLE;
          end
        end
        AACK, WACK: if (fall) begin
          if (!ph) begin
            sda_pull_o <= 1'b1; ph <= 1'b1;
          end else begin
            ph <= 1'b0; bcnt <= '0;
            if (st == AACK && rw) begin
              st <= RDATA; sh <= pend; sda_pull_o <= ~pend[7];
            end else begin
              st <= WDATA; sda_pull_o <= 1'b0;
            end
          end
        end
        WDATA: if (rise) begin
          sh   <= {sh[6:0], sda_f};
          bcnt <= bcnt + 1'b1;
          if (bcnt == 4'd7) begin
            pend <= {sh[6:0], sda_f}; st <= WACK; ph <= 1'b0;
          end
        end
        RDATA: begin
          if (rise) bcnt <= bcnt + 1'b1;
          else if (fall) begin
            if (bcnt == 4'd8) begin
              sda_pull_o <= 1'b0; st <= RACK; ph <= 1'b0;
            end else begin
              sda_pull_o <= ~sh[6]; sh <= {sh[6:0], 1'b0};
            end
          end
        end
        RACK: begin
          if (rise) begin
            if (sda_f) st <= IDLE;
            else       ph <= 1'b1;
          end else if (fall && ph) begin
            st <= RDATA; bcnt <= '0; ph <= 1'b0; sh <= pend; sda_pull_o <= ~pend[7];
          end
        end
        default: ;
      endcase
    end
  end

  // R4
  en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(chan_en_o) |-> $past(stop));
  // R4
  en_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> chan_en_o == $past(pend));
  // R11
  pull_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull_o) |-> !scl_f);
  // R8
  rs_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> st == ADDR && !sda_pull_o && bcnt == 4'd0);
  // R3
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st == IDLE |-> !sda_pull_o);
endmodule

// File: tb/tb_i2c_chan_sel.sv
module tb_i2c_chan_sel;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1, sda_m = 1'b1;
  logic [2:0] strap = 3'b101;
  logic       sda_pull;
  logic [7:0] chan_en;
  logic       bus;
  int         checks = 0, fails = 0;
  logic [7:0] exp_chan = 8'h00, exp_pend = 8'h00;
  logic       mon_on = 1'b0, done = 1'b0, prev_pull = 1'b0;

  always #10 clk = ~clk;
  assign bus = sda_m & ~sda_pull;

  i2c_chan_sel dut (.clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(bus),
    .strap_i(strap), .sda_pull_o(sda_pull), .chan_en_o(chan_en));

  // Reference model of the applied mask, compared every clock (R4)
  always @(negedge clk) begin
    if (rst_n && mon_on && !done) begin
      checks++;
      if (chan_en !== exp_chan) begin
        fails++;
        $display("FAIL R4 chan_en actual=%0h expected=%0h", chan_en, exp_chan);
      end
    end
    if (rst_n && !done && sda_pull !== prev_pull) begin
      checks++;
      if (scl_m !== 1'b0) begin
        fails++;
        $display("FAIL R11 pull changed with scl actual=%0b expected=0", scl_m);
      end
    end
    prev_pull = sda_pull;
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bitx(input logic b, input int g, output logic r);
    scl_m = 1'b0; tick(6); sda_m = b;
    if (g == 1) begin tick(2); scl_m = 1'b1; tick(2); scl_m = 1'b0; tick(2); end
    else tick(6);
    scl_m = 1'b1; tick(3);
    if (g == 2) begin sda_m = 1'b0; tick(2); sda_m = b; tick(1); end
    else tick(3);
    r = bus; tick(6);
  endtask

  task automatic send_byte(input logic [7:0] v, input int gpos, input int gk, output logic ack);
    logic r;
    for (int i = 0; i < 8; i++) bitx(v[7-i], (i == gpos) ? gk : 0, r);
    bitx(1'b1, 0, r);
    ack = ~r;
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] v);
    logic r;
    for (int i = 0; i < 8; i++) begin bitx(1'b1, 0, r); v[7-i] = r; end
    bitx(~mack, 0, r);
  endtask

  task automatic start_c();
    scl_m = 1'b0; tick(6); sda_m = 1'b1; tick(6);
    scl_m = 1'b1; tick(12); sda_m = 1'b0; tick(12);
  endtask

  task automatic stop_c();
    scl_m = 1'b0; tick(6); sda_m = 1'b0; tick(6);
    scl_m = 1'b1; tick(12);
    mon_on = 1'b0; sda_m = 1'b1; tick(12);
    exp_chan = exp_pend; mon_on = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog R1 actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic ack, r;
    logic [7:0] v;
    tick(2);
    chk("R1 enables in reset", chan_en, 8'h00);
    chk("R1 pull in reset", {7'd0, sda_pull}, 8'h00);
    tick(3); rst_n = 1'b1; tick(4); mon_on = 1'b1;
    chk("R1 enables after reset", chan_en, 8'h00);

    // single write, applied only at STOP
    start_c();
    send_byte(8'hEA, -1, 0, ack); chk("R2 write address ack", {7'd0, ack}, 8'h01);
    send_byte(8'h5A, -1, 0, ack); chk("R4 data ack", {7'd0, ack}, 8'h01);
    exp_pend = 8'h5A;
    chk("R4 held before stop", chan_en, 8'h00);
    stop_c();
    chk("R4 applied after stop", chan_en, 8'h5A);

    // burst write, last byte wins
    start_c();
    send_byte(8'hEA, -1, 0, ack);
    send_byte(8'h11, -1, 0, ack); chk("R5 byte1 ack", {7'd0, ack}, 8'h01);
    send_byte(8'h22, -1, 0, ack); chk("R5 byte2 ack", {7'd0, ack}, 8'h01);
    send_byte(8'h81, -1, 0, ack); chk("R5 byte3 ack", {7'd0, ack}, 8'h01);
    exp_pend = 8'h81;
    stop_c();
    chk("R5 last byte applied", chan_en, 8'h81);

    // single read with NACK
    start_c();
    send_byte(8'hEB, -1, 0, ack); chk("R2 read address ack", {7'd0, ack}, 8'h01);
    recv_byte(1'b0, v); chk("R6 read value", v, 8'h81);
    tick(8); chk("R6 released after nack", {7'd0, sda_pull}, 8'h00);
    stop_c();

    // read with ACK then NACK
    start_c();
    send_byte(8'hEB, -1, 0, ack);
    recv_byte(1'b1, v); chk("R7 first read byte", v, 8'h81);
    recv_byte(1'b0, v); chk("R7 second read byte", v, 8'h81);
    stop_c();

    // non-matching address
    start_c();
    send_byte(8'hE0, -1, 0, ack); chk("R3 no ack on mismatch", {7'd0, ack}, 8'h00);
    send_byte(8'h00, -1, 0, ack); chk("R3 data ignored", {7'd0, ack}, 8'h00);
    stop_c();
    chk("R3 mask unchanged", chan_en, 8'h81);

    // repeated START after a full byte and after a partial byte
    start_c();
    send_byte(8'hEA, -1, 0, ack);
    send_byte(8'h3C, -1, 0, ack);
    exp_pend = 8'h3C;
    start_c();
    send_byte(8'hEA, -1, 0, ack); chk("R8 ack after repeated start", {7'd0, ack}, 8'h01);
    for (int i = 0; i < 3; i++) bitx(1'b0, 0, r);
    start_c();
    send_byte(8'hEB, -1, 0, ack); chk("R8 read address after abort", {7'd0, ack}, 8'h01);
    recv_byte(1'b0, v); chk("R8 staged byte kept", v, 8'h3C);
    chk("R8 not applied before stop", chan_en, 8'h81);
    stop_c();
    chk("R8 applied at stop", chan_en, 8'h3C);

    // straps latched at START
    start_c();
    strap = 3'b010;
    send_byte(8'hEA, -1, 0, ack); chk("R9 old strap still matches", {7'd0, ack}, 8'h01);
    send_byte(8'hFF, -1, 0, ack); exp_pend = 8'hFF;
    stop_c();
    chk("R9 write with latched strap", chan_en, 8'hFF);
    start_c();
    send_byte(8'hEA, -1, 0, ack); chk("R9 new strap rejects old address", {7'd0, ack}, 8'h00);
    stop_c();
    start_c();
    send_byte(8'hE4, -1, 0, ack); chk("R9 new strap address ack", {7'd0, ack}, 8'h01);
    send_byte(8'h0F, -1, 0, ack); exp_pend = 8'h0F;
    stop_c();
    chk("R9 applied", chan_en, 8'h0F);
    strap = 3'b101;

    // glitch rejection on SCL and SDA
    start_c();
    send_byte(8'hEA, 3, 1, ack); chk("R10 address with scl glitch", {7'd0, ack}, 8'h01);
    send_byte(8'hA5, 5, 2, ack); chk("R10 data with sda glitch", {7'd0, ack}, 8'h01);
    exp_pend = 8'hA5;
    stop_c();
    chk("R10 value intact", chan_en, 8'hA5);

    // reset mid-transaction
    start_c();
    send_byte(8'hEA, -1, 0, ack);
    send_byte(8'h77, -1, 0, ack);
    mon_on = 1'b0; tick(1);
    rst_n = 1'b0; exp_pend = 8'h00; exp_chan = 8'h00;
    tick(2);
    chk("R1 enables cleared", chan_en, 8'h00);
    chk("R1 pull cleared", {7'd0, sda_pull}, 8'h00);
    scl_m = 1'b1; sda_m = 1'b1; tick(4);
    rst_n = 1'b1; tick(2); mon_on = 1'b1;
    start_c();
    send_byte(8'hEB, -1, 0, ack);
    recv_byte(1'b0, v); chk("R1 staged cleared", v, 8'h00);
    stop_c();
    chk("R1 enables stay clear", chan_en, 8'h00);

    tick(10);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule